// File: doc/BRIEF.md
# Shared Store Ownership Acquirer

This block obtains exclusive use of a shared non-volatile store on behalf of its host logic. A one-cycle acquire pulse starts a request/grant exchange with an external arbiter. Every arbiter answer, whether it grants or refuses, carries a hold time in milliseconds. The block scales that hold time to ticks of a free-running timer supplied by the host, and adds it to the timer value to form a deadline.

When the first request is refused, the block sets a polling window. The window ends at the timer value plus the owner's reported hold time, but never later than a configured maximum hold. While the timer is still inside that window, it waits a fixed number of clock cycles and asks again. The acquisition ends with a one-cycle done pulse and a granted flag. After a grant, the expiry deadline of the ownership is stored. After a failure, the expiry is cleared and a time before which a new attempt is pointless is stored instead.

A release pulse hands ownership back with a single release command. A blank-mode input bypasses the arbiter entirely: acquisition succeeds at once and release sends nothing.

Top module: `own_acquirer`

## Requirements
- R1: After reset, `done`, `granted`, `owned`, `arb_req`, `arb_rel`, `expiry_at` and `wait_until` are all zero.
- R2: With `blank_mode` high, an accepted acquire gives `done` and `granted` high on the next cycle, issues no `arb_req`, and leaves `expiry_at` and `wait_until` unchanged. A release with `blank_mode` high issues no `arb_rel` and clears `owned`.
- R3: Every attempt raises `arb_req` for exactly one cycle, and each attempt gets exactly one response.
- R4: A grant on the first attempt sets `expiry_at` to `timer_now + resp_hold_ms*TICKS_PER_MS`, using the timer value of the response cycle. On the next cycle it also pulses `done` with `granted` high and sets `owned`.
- R5: On a first refusal, the polling window ends at the response-cycle timer plus min(`resp_hold_ms`, `MAX_HOLD_MS`) × `TICKS_PER_MS`. A further attempt is made only if the timer at a refused response is strictly below that end.
- R6: After a refusal that continues polling, the next `arb_req` rises `RETRY_CYCLES`+1 cycles after the response cycle.
- R7: A grant on a later attempt sets `expiry_at` from that response's hold time and timer value.
- R8: When a refusal arrives outside the window, `done` pulses with `granted` low. At the same time `expiry_at` becomes 0 and `wait_until` becomes that response's hold time in ticks plus its timer value. A zero hold time on the first refusal fails at once.
- R9: A release while `owned` is high, outside blank mode, produces one `arb_rel` pulse on the next cycle and clears `owned`. A release while not owned produces no `arb_rel`.
- R10: An acquire pulse that arrives while an acquisition is in progress is ignored. It adds no attempt and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blank_mode | input | 1 | Bypass the arbiter |
| acq_req | input | 1 | One-cycle acquire request |
| rel_req | input | 1 | One-cycle release request |
| timer_now | input | TIMER_W | Free-running timer value |
| arb_req | output | 1 | Request command to the arbiter |
| arb_rel | output | 1 | Release command to the arbiter |
| resp_valid | input | 1 | Arbiter answer present |
| resp_grant | input | 1 | Answer is a grant |
| resp_hold_ms | input | HOLD_W | Hold time in milliseconds |
| done | output | 1 | Acquisition finished (one cycle) |
| granted | output | 1 | Outcome, valid with done |
| owned | output | 1 | Ownership currently held |
| expiry_at | output | TIMER_W | Ownership expiry deadline |
| wait_until | output | TIMER_W | Earliest useful retry time after failure |

## Verification
The properties assume the arbiter answers each request exactly once, while the block waits for an answer, and never without a pending request. They also assume that a release is not issued in the same cycle as a grant. The bench's arbiter model answers one cycle after each request and never sends an unsolicited answer. Releases are issued only when the block is idle. The timer starts near zero and counts once per clock, so deadline sums never wrap.

// File: rtl/own_pkg.sv
package own_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_PAUSE = 2'd3
  } own_state_t;
endpackage

// File: rtl/own_deadline_calc.sv
// Converts a millisecond hold time into timer ticks and forms deadlines.
module own_deadline_calc #(
  parameter int TIMER_W      = 32,
  parameter int HOLD_W       = 16,
  parameter int TICKS_PER_MS = 1000,
  parameter int MAX_HOLD_MS  = 18000
) (
  input  logic [TIMER_W-1:0] now,
  input  logic [HOLD_W-1:0]  hold_ms,
  output logic [TIMER_W-1:0] expiry_at,
  output logic [TIMER_W-1:0] window_end
);
  localparam logic [HOLD_W-1:0]  CAP_MS = HOLD_W'(MAX_HOLD_MS);
  localparam logic [TIMER_W-1:0] SCALE  = TIMER_W'(TICKS_PER_MS);

  logic [HOLD_W-1:0] capped_ms;

  always_comb begin
    capped_ms  = (hold_ms > CAP_MS) ? CAP_MS : hold_ms;
    expiry_at  = now + TIMER_W'(hold_ms) * SCALE;
    window_end = now + TIMER_W'(capped_ms) * SCALE;
  end
endmodule

// File: rtl/own_retry_timer.sv
// Counts the fixed pause between refused attempts.
module own_retry_timer #(
  parameter int CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fire
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          active;

  assign fire = active && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      cnt    <= LOAD;
      active <= 1'b1;
    end else if (fire) begin
      active <= 1'b0;
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/own_ctrl_fsm.sv
// Sequencing of attempts, outcome registers and release handling.
module own_ctrl_fsm
  import own_pkg::*;
#(
  parameter int TIMER_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               blank_mode,
  input  logic               acq_req,
  input  logic               rel_req,
  input  logic               resp_valid,
  input  logic               resp_grant,
  input  logic [TIMER_W-1:0] now,
  input  logic [TIMER_W-1:0] calc_expiry,
  input  logic [TIMER_W-1:0] calc_window,
  input  logic               pause_fire,
  output logic               pause_start,
  output own_state_t         state,
  output logic               arb_rel,
  output logic               done,
  output logic               granted,
  output logic               owned,
  output logic [TIMER_W-1:0] expiry_at,
  output logic [TIMER_W-1:0] wait_until
);
  logic               first_try;
  logic [TIMER_W-1:0] window_reg;
  logic               keep_polling;
  logic               refused;

  assign refused      = (state == ST_WAIT) && resp_valid && !resp_grant;
  assign keep_polling = first_try ? (now < calc_window) : (now < window_reg);
  assign pause_start  = refused && keep_polling;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      first_try  <= 1'b0;
      window_reg <= '0;
      arb_rel    <= 1'b0;
      done       <= 1'b0;
      granted    <= 1'b0;
      owned      <= 1'b0;
      expiry_at  <= '0;
      wait_until <= '0;
    end else begin
      done    <= 1'b0;
      granted <= 1'b0;
      arb_rel <= 1'b0;
      if (rel_req) begin
        owned <= 1'b0;
        if (owned && !blank_mode) arb_rel <= 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (acq_req) begin
            if (blank_mode) begin
              done    <= 1'b1;
              granted <= 1'b1;
            end else begin
              state     <= ST_SEND;
              first_try <= 1'b1;
            end
          end
        end
        ST_SEND: state <= ST_WAIT;
        ST_WAIT: begin
          if (resp_valid) begin
            if (resp_grant) begin
              expiry_at <= calc_expiry;
              owned     <= 1'b1;
              done      <= 1'b1;
              granted   <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              if (first_try) begin
                window_reg <= calc_window;
                expiry_at  <= calc_expiry;
                first_try  <= 1'b0;
              end
              if (keep_polling) begin
                state <= ST_PAUSE;
              end else begin
                expiry_at  <= '0;
                wait_until <= calc_expiry;
                done       <= 1'b1;
                state      <= ST_IDLE;
              end
            end
          end
        end
        ST_PAUSE: if (pause_fire) state <= ST_SEND;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/own_acquirer.sv
module own_acquirer
  import own_pkg::*;
#(
  parameter int TIMER_W      = 32,
  parameter int HOLD_W       = 16,
  parameter int TICKS_PER_MS = 1000,
  parameter int MAX_HOLD_MS  = 18000,
  parameter int RETRY_CYCLES = 1000000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               blank_mode,
  input  logic               acq_req,
  input  logic               rel_req,
  input  logic [TIMER_W-1:0] timer_now,
  output logic               arb_req,
  output logic               arb_rel,
  input  logic               resp_valid,
  input  logic               resp_grant,
  input  logic [HOLD_W-1:0]  resp_hold_ms,
  output logic               done,
  output logic               granted,
  output logic               owned,
  output logic [TIMER_W-1:0] expiry_at,
  output logic [TIMER_W-1:0] wait_until
);
  logic [TIMER_W-1:0] calc_expiry;
  logic [TIMER_W-1:0] calc_window;
  logic               pause_start;
  logic               pause_fire;
  own_state_t         fsm_state;

  own_deadline_calc #(
    .TIMER_W(TIMER_W), .HOLD_W(HOLD_W),
    .TICKS_PER_MS(TICKS_PER_MS), .MAX_HOLD_MS(MAX_HOLD_MS)
  ) u_calc (
    .now(timer_now), .hold_ms(resp_hold_ms),
    .expiry_at(calc_expiry), .window_end(calc_window)
  );

  own_retry_timer #(.CYCLES(RETRY_CYCLES)) u_pause (
    .clk(clk), .rst(rst), .start(pause_start), .fire(pause_fire)
  );

  own_ctrl_fsm #(.TIMER_W(TIMER_W)) u_fsm (
    .clk(clk), .rst(rst), .blank_mode(blank_mode),
    .acq_req(acq_req), .rel_req(rel_req),
    .resp_valid(resp_valid), .resp_grant(resp_grant),
    .now(timer_now), .calc_expiry(calc_expiry), .calc_window(calc_window),
    .pause_fire(pause_fire), .pause_start(pause_start), .state(fsm_state),
    .arb_rel(arb_rel), .done(done), .granted(granted), .owned(owned),
    .expiry_at(expiry_at), .wait_until(wait_until)
  );

  assign arb_req = (fsm_state == ST_SEND);
endmodule

// File: rtl/own_acq_checker.sv
module own_acq_checker
  import own_pkg::*;
#(
  parameter int TIMER_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               blank_mode,
  input logic               acq_req,
  input logic               resp_valid,
  input logic               resp_grant,
  input own_state_t         state,
  input logic               arb_req,
  input logic               arb_rel,
  input logic               done,
  input logic               granted,
  input logic               owned,
  input logic [TIMER_W-1:0] expiry_at
);
  assert_blank_done_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && acq_req && blank_mode) |=> (done && granted && !arb_req));

  assert_req_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    arb_req |=> !arb_req);

  assert_grant_owned_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && resp_valid && resp_grant) |=> (done && granted && owned));

  assert_pause_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && resp_valid && !resp_grant) |=> !arb_req);

  assert_fail_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !granted) |-> (expiry_at == '0));

  assert_rel_once_R9: assert property (@(posedge clk) disable iff (rst)
    arb_rel |-> ($past(owned) && !owned));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && acq_req) |=> !done || state == ST_IDLE);
endmodule

bind own_acquirer own_acq_checker #(.TIMER_W(TIMER_W)) u_chk (
  .clk(clk), .rst(rst), .blank_mode(blank_mode), .acq_req(acq_req),
  .resp_valid(resp_valid), .resp_grant(resp_grant), .state(fsm_state),
  .arb_req(arb_req), .arb_rel(arb_rel), .done(done), .granted(granted),
  .owned(owned), .expiry_at(expiry_at)
);

// File: tb/tb_own_acquirer.sv
`timescale 1ns/1ps
module tb_own_acquirer;
  localparam int TW = 32, HW = 16, TPM = 3, MAXMS = 10, RETRY = 6;

  typedef struct { bit g; int h; } resp_t;
  typedef struct { bit g; logic [31:0] ex; logic [31:0] wt; int n; } item_t;

  logic clk = 0, rst = 1, blank_mode = 0, acq_req = 0, rel_req = 0;
  logic [TW-1:0] tmr = 0;
  logic resp_valid = 0, resp_grant = 0;
  logic [HW-1:0] resp_hold_ms = 0;
  logic arb_req, arb_rel, done, granted, owned;
  logic [TW-1:0] expiry_at, wait_until;

  own_acquirer #(.TIMER_W(TW), .HOLD_W(HW), .TICKS_PER_MS(TPM),
                 .MAX_HOLD_MS(MAXMS), .RETRY_CYCLES(RETRY)) dut (
    .clk(clk), .rst(rst), .blank_mode(blank_mode), .acq_req(acq_req),
    .rel_req(rel_req), .timer_now(tmr), .arb_req(arb_req), .arb_rel(arb_rel),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_hold_ms(resp_hold_ms),
    .done(done), .granted(granted), .owned(owned),
    .expiry_at(expiry_at), .wait_until(wait_until));

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0, done_cnt = 0, req_total = 0;
  bit finished = 0;
  resp_t script[$];
  item_t expq[$];
  int    nq[$];
  logic [31:0] mdl_exp = 0, mdl_wait = 0, mpoll = 0, retry_at = 0;
  bit mfirst = 1, pend = 0, prev_req = 0;
  int acq_reqs = 0;

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Arbiter model and timer; pushes expected outcomes
  initial begin
    forever begin
      @(negedge clk);
      tmr = tmr + 1;
      resp_valid = 0;
      if (pend) begin
        resp_t r;
        logic [31:0] e;
        pend = 0;
        if (script.size() > 0) r = script.pop_front();
        else begin r.g = 0; r.h = 0; end
        resp_valid = 1; resp_grant = r.g; resp_hold_ms = HW'(r.h);
        e = tmr + 32'(r.h) * TPM;
        if (r.g) begin
          mdl_exp = e;
          expq.push_back('{1'b1, e, mdl_wait, acq_reqs});
          mfirst = 1; acq_reqs = 0; retry_at = 0;
        end else begin
          if (mfirst) begin
            mpoll = tmr + 32'((r.h > MAXMS) ? MAXMS : r.h) * TPM;
            mdl_exp = e; mfirst = 0;
          end
          if (tmr < mpoll) retry_at = tmr + RETRY + 1;
          else begin
            mdl_exp = 0; mdl_wait = e;
            expq.push_back('{1'b0, 32'd0, e, acq_reqs});
            mfirst = 1; acq_reqs = 0; retry_at = 0;
          end
        end
      end
      if (!rst && arb_req) begin
        if (prev_req) check("R3 request longer than one cycle", 1, 0);
        req_total++; acq_reqs++; pend = 1;
        if (retry_at != 0) begin
          check("R6 retry spacing", tmr, retry_at);
          retry_at = 0;
        end
      end
      prev_req = !rst && arb_req;
    end
  end

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        done_cnt++;
        if (expq.size() == 0 || nq.size() == 0) check("R10 unexpected done", 1, 0);
        else begin
          item_t it; int n;
          it = expq.pop_front(); n = nq.pop_front();
          check("R4/R8 granted flag", 32'(granted), 32'(it.g));
          check("R4/R7/R8 expiry_at", expiry_at, it.ex);
          check("R8 wait_until", wait_until, it.wt);
          check("R3/R5/R10 attempts", it.n, n);
        end
      end
    end
  end

  task automatic acquire(int n_expect, bit poke);
    int d0;
    nq.push_back(n_expect);
    d0 = done_cnt;
    @(negedge clk); acq_req = 1;
    @(negedge clk); acq_req = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      acq_req = 1;
      @(negedge clk); acq_req = 0;
    end
    wait (done_cnt != d0);
    repeat (2) @(negedge clk);
  endtask

  task automatic release_pulse(bit expect_cmd);
    @(negedge clk); rel_req = 1;
    @(negedge clk); rel_req = 0;
    check("R9/R2 release command", 32'(arb_rel), 32'(expect_cmd));
    check("R9/R2 owned cleared", 32'(owned), 0);
    @(negedge clk);
    check("R9 release single pulse", 32'(arb_rel), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 done", 32'(done), 0);
    check("R1 granted", 32'(granted), 0);
    check("R1 owned", 32'(owned), 0);
    check("R1 arb_req", 32'(arb_req), 0);
    check("R1 arb_rel", 32'(arb_rel), 0);
    check("R1 expiry_at", expiry_at, 0);
    check("R1 wait_until", wait_until, 0);

    // R4 grant on first attempt
    script.push_back('{1'b1, 5});
    acquire(1, 0);
    check("R4 owned after grant", 32'(owned), 1);
    release_pulse(1);   // R9 owned release
    release_pulse(0);   // R9 release while not owned

    // R8 fail inside short window, R6 spacing
    script.push_back('{1'b0, 4}); script.push_back('{1'b0, 4}); script.push_back('{1'b0, 2});
    acquire(3, 0);
    check("R8 owned stays low", 32'(owned), 0);

    // R5 cap at maximum hold, R10 acquire while busy ignored
    repeat (8) script.push_back('{1'b0, 50});
    acquire(5, 1);
    script.delete();
    begin
      int d1, r1;
      d1 = done_cnt; r1 = req_total;
      repeat (20) @(negedge clk);
      check("R10 no extra done", done_cnt, d1);
      check("R10 no extra request", req_total, r1);
    end

    // R7 grant after a retry
    script.push_back('{1'b0, 4}); script.push_back('{1'b1, 7});
    acquire(2, 0);

    // R8 zero hold fails immediately
    script.push_back('{1'b0, 0});
    acquire(1, 0);
    release_pulse(1);

    // R2 blank mode
    script.push_back('{1'b1, 3});
    acquire(1, 0);
    blank_mode = 1;
    begin
      int r2;
      r2 = req_total;
      expq.push_back('{1'b1, mdl_exp, mdl_wait, 0});
      acquire(0, 0);
      check("R2 no request in blank mode", req_total, r2);
    end
    release_pulse(0);
    blank_mode = 0;

    check("R10 scoreboard drained", expq.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule